// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog that only declares a failure after a 35-bit down counter has run out twice in a row with no restart from the host. The first run of the counter is loaded from one preload register. When it reaches zero, the counter reloads from a second preload register and runs a second time. Only the end of that second run raises a timeout. A host restart always returns the counter to the first run.

Three registers are protected: the two preload values and the control word. A write to any of them is accepted only when it directly follows a key pair written to the control address. An unlocked window is spent by the very next write. On a timeout the block sets a sticky status bit and acts on an active-low output. That output either latches low or toggles on each timeout, as a configuration input selects. A free-running mode turns every expiry into a timeout and opens the protected registers without keys.

Two reset inputs are provided. The power-on reset clears everything. The system reset clears the counter, the key detector, the preloads and the output, but leaves the status bit intact. Both resets are asserted asynchronously and released through two-flop synchronisers, so functional updates begin on the third rising clock edge after release.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset, the block comes up in a defined state:
  - counter = preload reset value (all ones, zero-extended to 35 bits);
  - stage = first (`stage_o` = 0);
  - `tmo_status` = 0;
  - `wdt_tout_n` = 1.
- R2: While the counter is non-zero and no restart is accepted, it decreases by exactly one each clock. It is 35 bits wide.
- R3: When the counter is zero in the first stage (not free-running, no restart), the next cycle shows `stage_o` = 1 and the counter holds preload 2. No timeout is raised at this point.
- R4: When the counter is zero in the second stage, the next cycle shows three things: `tmo_status` = 1, `stage_o` = 0, and the counter reloaded from preload 1.
- R5: Writing low byte 0x80 and then 0x86 to address 0xC opens exactly one write. Address map: 0x0 is preload 1, 0x4 is preload 2, 0xC is control. The write after the pair is accepted whatever its address, and the write after that is locked again.
- R6: A protected write without a completed key pair has no effect. A write that breaks the 0x80, 0x86 order returns the detector to idle, so a later 0x86 alone does not unlock.
- R7: An accepted control write with bit 8 = 1 restarts the counter from preload 1 in the first stage. If the counter expires in that same cycle, the restart wins and no timeout is raised.
- R8: An accepted control write with bit 9 = 1 clears `tmo_status`. If a timeout occurs in the same cycle, the set wins.
- R9: The timeout output behaves according to `cfg_toggle`:
  - `cfg_toggle` = 0: a timeout drives `wdt_tout_n` low, and it stays low.
  - `cfg_toggle` = 1: each timeout inverts `wdt_tout_n`.
- R10: System reset has these effects:
  - `tmo_status` is kept;
  - the counter, stage, preloads and output are reset.
  Power-on reset clears `tmo_status`.
- R11: With `cfg_free_run` = 1:
  - every counter expiry raises a timeout and reloads preload 1;
  - protected writes are accepted without keys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| cfg_toggle | input | 1 | 1: output toggles per timeout; 0: output latches low |
| cfg_free_run | input | 1 | Free-running mode enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (0x0, 0x4, 0xC) |
| wr_data | input | DATA_W | Write data |
| wdt_tout_n | output | 1 | Active-low timeout output |
| tmo_status | output | 1 | Sticky timeout status |
| cnt_o | output | CNT_W | Current counter value |
| stage_o | output | 1 | 0: first stage, 1: second stage |

## Verification
Two pairs of events can land in the same cycle:
- a host restart arriving in the cycle where the second-stage counter reads zero;
- a status clear arriving in a cycle where a timeout is being raised.

The bench provokes both the same way. It writes the key pair early, idles while the reference model tracks the count, and issues the restart or clear exactly in the cycle the model shows second-stage zero. It then judges the result on the following cycle: the restart must suppress the timeout, and the set must survive the clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADDR_KEY = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              free_run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              gate_o
);
  lock_e state_q, state_d;
  logic  hit_first, hit_second;

  assign hit_first  = (wr_addr == ADDR_KEY) && (wr_data[7:0] == KEY_FIRST);
  assign hit_second = (wr_addr == ADDR_KEY) && (wr_data[7:0] == KEY_SECOND);

  always_comb begin
    state_d = state_q;
    if (free_run) begin
      state_d = LK_IDLE;
    end else if (wr_en) begin
      case (state_q)
        LK_IDLE: state_d = hit_first  ? LK_HALF : LK_IDLE;
        LK_HALF: state_d = hit_second ? LK_OPEN : LK_IDLE;
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign gate_o = free_run || (state_q == LK_OPEN);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 35,
  parameter int PRE_W = 32,
  parameter logic [PRE_W-1:0] PRE_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             free_run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stage_o,
  output logic             expire_o
);
  localparam int PAD = CNT_W - PRE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stage_q, stage_d;
  logic [CNT_W-1:0] load1, load2;

  assign load1 = {{PAD{1'b0}}, pre1};
  assign load2 = {{PAD{1'b0}}, pre2};

  always_comb begin
    cnt_d    = cnt_q - 1'b1;
    stage_d  = stage_q;
    expire_o = 1'b0;
    if (restart) begin
      cnt_d   = load1;
      stage_d = 1'b0;
    end else if (cnt_q == '0) begin
      if (free_run || stage_q) begin
        expire_o = 1'b1;
        cnt_d    = load1;
        stage_d  = 1'b0;
      end else begin
        cnt_d    = load2;
        stage_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= {{PAD{1'b0}}, PRE_RST};
      stage_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign stage_o = stage_q;
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage #(
  parameter int CNT_W  = 35,
  parameter int PRE_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [PRE_W-1:0] PRE_RST = '1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              cfg_toggle,
  input  logic              cfg_free_run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_tout_n,
  output logic              tmo_status,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              stage_o
);
  localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(12);
  localparam int                RELOAD_B  = 8;
  localparam int                CLEAR_B   = 9;
  localparam int                NUM_PRE   = 2;

  logic rst_por_n, rst_sys_n;
  logic gate, acc, ctl_hit, host_reload, host_clear, expire;
  logic stat_q, stat_d, out_q, out_d;
  logic [PRE_W-1:0] pre1_w, pre2_w;

  wdt_rst_sync #(.STAGES(2)) u_sync_por (
    .clk(clk), .arst_n(por_n), .rst_n_o(rst_por_n)
  );
  wdt_rst_sync #(.STAGES(2)) u_sync_sys (
    .clk(clk), .arst_n(por_n & sys_rst_n), .rst_n_o(rst_sys_n)
  );

  wdt_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_KEY(ADDR_CTL)) u_unlock (
    .clk(clk), .rst_n(rst_sys_n), .free_run(cfg_free_run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .gate_o(gate)
  );

  assign acc         = wr_en && gate;
  assign ctl_hit     = acc && (wr_addr == ADDR_CTL);
  assign host_reload = ctl_hit && wr_data[RELOAD_B];
  assign host_clear  = ctl_hit && wr_data[CLEAR_B];

  for (genvar i = 0; i < NUM_PRE; i++) begin : g_pre
    logic [PRE_W-1:0] q;
    logic             en;
    assign en = acc && (wr_addr == ADDR_W'(4 * i));
    always_ff @(posedge clk or negedge rst_sys_n) begin
      if (!rst_sys_n) q <= PRE_RST;
      else if (en)    q <= wr_data[PRE_W-1:0];
    end
  end

  assign pre1_w = g_pre[0].q;
  assign pre2_w = g_pre[1].q;

  wdt_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_cnt (
    .clk(clk), .rst_n(rst_sys_n), .free_run(cfg_free_run),
    .restart(host_reload), .pre1(pre1_w), .pre2(pre2_w),
    .cnt_o(cnt_o), .stage_o(stage_o), .expire_o(expire)
  );

  always_comb begin
    stat_d = stat_q;
    if (expire)          stat_d = 1'b1;
    else if (host_clear) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) stat_q <= 1'b0;
    else            stat_q <= stat_d;
  end

  always_comb begin
    out_d = out_q;
    if (expire) out_d = cfg_toggle ? ~out_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) out_q <= 1'b1;
    else            out_q <= out_d;
  end

  assign tmo_status = stat_q;
  assign wdt_tout_n = out_q;
endmodule

// File: rtl/wdt_dual_stage_chk.sv
module wdt_dual_stage_chk #(
  parameter int CNT_W  = 35,
  parameter int PRE_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_sys_n,
  input logic              rst_por_n,
  input logic              wr_en,
  input logic              gate,
  input logic              cfg_toggle,
  input logic              cfg_free_run,
  input logic              host_reload,
  input logic              host_clear,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              stage_o,
  input logic [PRE_W-1:0]  pre1_w,
  input logic [PRE_W-1:0]  pre2_w,
  input logic              tmo_status,
  input logic              wdt_tout_n
);
  localparam int PAD = CNT_W - PRE_W;
  logic [CNT_W-1:0] p1x, p2x;
  assign p1x = {{PAD{1'b0}}, pre1_w};
  assign p2x = {{PAD{1'b0}}, pre2_w};

  // R2
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (cnt_o != '0 && !host_reload) |=> cnt_o == $past(cnt_o) - 1'b1);

  // R3
  stage_adv_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (cnt_o == '0 && !stage_o && !cfg_free_run && !host_reload)
      |=> (stage_o && cnt_o == $past(p2x)));

  // R4
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_sys_n)
    expire |=> tmo_status);

  // R6
  locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (wr_en && !gate) |=> ($stable(pre1_w) && $stable(pre2_w)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    host_reload |=> (!stage_o && cnt_o == $past(p1x)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_sys_n)
    (host_clear && !expire) |=> !tmo_status);

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (!wdt_tout_n && !cfg_toggle) |=> !wdt_tout_n);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (tmo_status && !host_clear) |=> tmo_status);
endmodule

bind wdt_dual_stage wdt_dual_stage_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_sys_n(rst_sys_n), .rst_por_n(rst_por_n),
  .wr_en(wr_en), .gate(gate), .cfg_toggle(cfg_toggle),
  .cfg_free_run(cfg_free_run), .host_reload(host_reload),
  .host_clear(host_clear), .expire(expire), .cnt_o(cnt_o),
  .stage_o(stage_o), .pre1_w(pre1_w), .pre2_w(pre2_w),
  .tmo_status(tmo_status), .wdt_tout_n(wdt_tout_n)
);

// File: tb/sim_wdt_dual_stage.sv
`timescale 1ns/1ps
module sim_wdt_dual_stage;
  localparam int CNT_W = 35;
  localparam int PRE_W = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam longint PRE_RST = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic por_n, sys_rst_n, cfg_toggle, cfg_free_run, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic wdt_tout_n, tmo_status, stage_o;
  logic [CNT_W-1:0] cnt_o;

  always #10 clk = ~clk;

  wdt_dual_stage u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .cfg_toggle(cfg_toggle), .cfg_free_run(cfg_free_run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_tout_n(wdt_tout_n), .tmo_status(tmo_status),
    .cnt_o(cnt_o), .stage_o(stage_o)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  // behavioural reference model
  longint m_cnt = PRE_RST, m_pre1 = PRE_RST, m_pre2 = PRE_RST;
  int  m_stage = 0, m_lock = 0, por_c = 0, all_c = 0;
  bit  m_stat = 0, m_out = 1;

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit tmo, clr, acc, rel;
    cyc++;
    por_c = por_n ? por_c + 1 : 0;
    all_c = (por_n && sys_rst_n) ? all_c + 1 : 0;
    tmo = 0; clr = 0;
    if (all_c > 2) begin
      acc = wr_en && (cfg_free_run || m_lock == 2);
      rel = acc && wr_addr == 12 && wr_data[8];
      clr = acc && wr_addr == 12 && wr_data[9];
      if (rel) begin m_cnt = m_pre1; m_stage = 0; end
      else if (m_cnt == 0) begin
        if (cfg_free_run || m_stage == 1) begin tmo = 1; m_cnt = m_pre1; m_stage = 0; end
        else begin m_cnt = m_pre2; m_stage = 1; end
      end else m_cnt = m_cnt - 1;
      if (acc && wr_addr == 0) m_pre1 = longint'(wr_data);
      if (acc && wr_addr == 4) m_pre2 = longint'(wr_data);
      if (cfg_free_run) m_lock = 0;
      else if (wr_en) begin
        if (m_lock == 0 && wr_addr == 12 && wr_data[7:0] == 8'h80) m_lock = 1;
        else if (m_lock == 1 && wr_addr == 12 && wr_data[7:0] == 8'h86) m_lock = 2;
        else m_lock = 0;
      end
      if (tmo) m_out = cfg_toggle ? !m_out : 1'b0;
    end else begin
      m_cnt = PRE_RST; m_pre1 = PRE_RST; m_pre2 = PRE_RST;
      m_stage = 0; m_lock = 0; m_out = 1;
    end
    if (por_c <= 2) m_stat = 0;
    else if (tmo) m_stat = 1;
    else if (clr) m_stat = 0;
    if (cyc > 100000 && !done) begin
      done = 1; nchk++; nfail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (cmp_on) begin
    check("R2 count", longint'(cnt_o), m_cnt);
    check("R3 stage", longint'(stage_o), longint'(m_stage));
    check("R4 status", longint'(tmo_status), longint'(m_stat));
    check("R9 output", longint'(wdt_tout_n), longint'(m_out));
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic keys();
    wr(12, 'h80); wr(12, 'h86);
  endtask

  task automatic wait_zero(input int st);
    for (int i = 0; i < 5000; i++) begin
      if (m_stage == st && m_cnt == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    por_n = 0; sys_rst_n = 0; cfg_toggle = 0; cfg_free_run = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    check("R1 count", longint'(cnt_o), PRE_RST);
    check("R1 stage", longint'(stage_o), 0);
    check("R1 status", longint'(tmo_status), 0);
    check("R1 output", longint'(wdt_tout_n), 1);
    repeat (3) @(negedge clk);

    // R6 locked write ignored
    wr(0, 5); keys(); wr(12, 'h100);
    check("R6 locked preload", longint'(cnt_o), PRE_RST);

    // R5/R7 programmed through keys
    keys(); wr(0, 10); keys(); wr(4, 6); keys(); wr(12, 'h100);
    check("R7 restart", longint'(cnt_o), 10);
    check("R7 stage", longint'(stage_o), 0);

    // R6 broken ordering
    wr(12, 'h80); wr(12, 'h81); wr(12, 'h86); wr(0, 3);
    wr(12, 'h80); wr(4, 1); wr(12, 'h86); wr(12, 'h100);
    keys(); wr(12, 'h100);
    check("R6 broken order", longint'(cnt_o), 10);

    // R5 window spent by one write
    keys(); wr(0, 7); wr(4, 2); keys(); wr(12, 'h100);
    check("R5 one write", longint'(cnt_o), 7);

    // R3 stage advance with unchanged preload 2
    wait_zero(0); @(negedge clk);
    check("R3 stage", longint'(stage_o), 1);
    check("R5 preload2 kept", longint'(cnt_o), 6);

    // R4 / R9 timeout
    wait_zero(1); @(negedge clk);
    check("R4 status", longint'(tmo_status), 1);
    check("R4 count", longint'(cnt_o), 7);
    check("R9 low", longint'(wdt_tout_n), 0);
    wait_zero(1); @(negedge clk);
    check("R9 stays low", longint'(wdt_tout_n), 0);

    // R8 clear
    keys(); wr(12, 'h200);
    check("R8 clear", longint'(tmo_status), 0);

    // R7 restart collides with expiry
    keys(); wait_zero(1); wr(12, 'h100);
    check("R7 collision status", longint'(tmo_status), 0);
    check("R7 collision count", longint'(cnt_o), 7);

    // R8 set beats clear
    wait_zero(1); @(negedge clk);
    keys(); wait_zero(1); wr(12, 'h200);
    check("R8 set wins", longint'(tmo_status), 1);

    // R9 toggle mode
    cfg_toggle = 1;
    wait_zero(1); @(negedge clk);
    check("R9 toggle high", longint'(wdt_tout_n), 1);
    wait_zero(1); @(negedge clk);
    check("R9 toggle low", longint'(wdt_tout_n), 0);

    // R10 system reset keeps status
    #2 sys_rst_n = 0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1;
    @(negedge clk);
    check("R10 status kept", longint'(tmo_status), 1);
    check("R10 output reset", longint'(wdt_tout_n), 1);
    check("R10 count reset", longint'(cnt_o), PRE_RST);
    #2 por_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    check("R10 por clears", longint'(tmo_status), 0);
    repeat (3) @(negedge clk);

    // R11 free-running mode
    cfg_free_run = 1; cfg_toggle = 0;
    @(negedge clk);
    wr(0, 4); wr(12, 'h100);
    check("R11 no keys", longint'(cnt_o), 4);
    wait_zero(0); @(negedge clk);
    check("R11 every expiry", longint'(tmo_status), 1);
    check("R11 reload", longint'(cnt_o), 4);
    wr(12, 'h200);
    check("R11 clear", longint'(tmo_status), 0);
    wait_zero(0); @(negedge clk);
    check("R11 again", longint'(tmo_status), 1);
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule